// File: doc/BRIEF.md
# Memory Supply Fault Supervisor

This block sits between the analog fault comparators of a two-output memory power supply and the power sequencer. It watches per-rail under-voltage and over-voltage flags, a termination-regulator over-current flag and a pair of temperature flags. From these it drives a global disable that overrides every regulator enable, a disable for the termination regulator alone, and a one-cycle request to start a fresh soft-start ramp. It also drives a power-good output and three status bits.

The three fault classes get three different responses. An under-voltage fault starts an automatic retry loop. All outputs stay off for a fixed number of soft-start periods, counted on a strobe from the sequencer, and then a restart is requested. The loop repeats for as long as the fault persists. Over-voltage and over-temperature faults set sticky latches. These clear only when power-on status is lost, or when the sleep-5 control input goes low and comes back high. The thermal latch also needs the temperature-recovered flag before it clears. A termination over-current disables only that regulator and releases it by itself once the flag drops. Every asynchronous input passes through a two-flop synchronizer and must stay asserted for two consecutive clocks before it has any effect.

Top module: `fsv_fault_supervisor`

## Requirements
- R1: Once `uv_flag` has passed the input filter on any rail and `ramp_busy` is low, `all_off` and `stat_uv` rise. They stay up until `ss_tick` has been sampled high for the third time. In the next cycle `all_off` is low, and `ss_restart` and `stat_uv` are high for exactly one cycle.
- R2: If the filtered under-voltage is still present after a restart, the off period starts again one cycle after the restart cycle. This repeats without limit. Once the flag has cleared, a restart leaves the block idle.
- R3: A filtered `ov_flag` on any rail sets `stat_ov` and drives `all_off` high.
- R4: The over-voltage latch stays set after `ov_flag` drops and while `slp5_n` is held low. It clears on a rising edge of `slp5_n`, or when `por_ok` is low.
- R5: A filtered `temp_hot` sets `stat_ot` and drives `all_off` high. A clear event (rising edge of `slp5_n`, or `por_ok` low) releases the latch only while `temp_cool` is high and `temp_hot` is low. Without that condition the event has no effect.
- R6: A filtered `tt_oc` raises `tt_off` and no other output. `tt_off` falls by itself once `tt_oc` is removed.
- R7: While `ramp_busy` is high, `uv_flag` has no effect.
- R8: `pgood` is the window state ANDed with `all_off` low. The window state is forced low when filtered `in_s0` is low. In S0 it is set by `tt_win_hi`, cleared by `tt_win_lo` (the set flag wins if both are high), and otherwise holds its value.
- R9: While an over-voltage or thermal fault is present or latched, the retry loop is idle. `stat_uv` stays low and no `ss_restart` is issued.
- R10: An input high for a single clock has no effect. An input held for two or more clocks, and applied before clock edge k+1, shows on the outputs after edge k+4.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | NUM_RAILS | Per-rail under-voltage comparator flags |
| ov_flag | input | NUM_RAILS | Per-rail over-voltage comparator flags |
| tt_oc | input | 1 | Termination-regulator over-current flag |
| temp_hot | input | 1 | Die temperature above the shutdown limit |
| temp_cool | input | 1 | Die temperature below the recovery limit |
| slp5_n | input | 1 | Sleep-5 control, active low |
| por_ok | input | 1 | Power-on status of the bias supplies |
| ss_tick | input | 1 | One-cycle strobe per soft-start period (synchronous) |
| ramp_busy | input | 1 | Soft-start ramp in progress (synchronous) |
| in_s0 | input | 1 | System is in the running state |
| tt_win_hi | input | 1 | Termination ratio above the rising threshold |
| tt_win_lo | input | 1 | Termination ratio below the falling threshold |
| all_off | output | 1 | Disable every regulator |
| tt_off | output | 1 | Disable the termination regulator only |
| ss_restart | output | 1 | One-cycle request for a new soft-start |
| pgood | output | 1 | Power good |
| stat_ov | output | 1 | Over-voltage latch state |
| stat_ot | output | 1 | Thermal latch state |
| stat_uv | output | 1 | Retry loop active |

## Verification
Each filtered input goes through three synchronizer and persistence flops and then one state register. A stimulus driven before edge k+1 therefore shows after edge k+4. The exception is `ss_tick`, which feeds the retry counter directly, so the restart pulse follows one edge after the third strobe. The driver stamps every expected output vector with the cycle in which it is due, using these latencies. The monitor compares the whole output vector at the falling edge of exactly that cycle. Checks for "stays latched" and "ignored" are placed several cycles past the point where the change would have shown.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
  typedef enum logic [1:0] {
    HC_IDLE    = 2'd0,
    HC_OFF     = 2'd1,
    HC_RESTART = 2'd2
  } hic_state_e;
endpackage

// File: rtl/fsv_sync_filter.sv
module fsv_sync_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = din;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  // level must be seen on two consecutive synchronized samples
  assign dout = s2_q & s3_q;
endmodule

// File: rtl/fsv_hard_latch.sv
module fsv_hard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_ok_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i)                   q_d = 1'b1;
    else if (clr_i && clr_ok_i)  q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !(clr_i && clr_ok_i)) |=> q_q);
endmodule

// File: rtl/fsv_hiccup.sv
module fsv_hiccup
  import fsv_pkg::*;
#(
  parameter int RETRY_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_hit,
  input  logic hold,
  input  logic ss_tick,
  output logic off_o,
  output logic restart_o,
  output logic active_o
);
  localparam int CNT_W = $clog2(RETRY_PERIODS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_PERIODS - 1);

  hic_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      HC_IDLE: begin
        cnt_d = '0;
        if (!hold && uv_hit) st_d = HC_OFF;
      end
      HC_OFF: begin
        if (hold) begin
          st_d  = HC_IDLE;
          cnt_d = '0;
        end else if (ss_tick) begin
          if (cnt_q == LAST) begin
            st_d  = HC_RESTART;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      HC_RESTART: begin
        st_d  = HC_IDLE;
        cnt_d = '0;
      end
      default: begin
        st_d  = HC_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign off_o     = (st_q == HC_OFF);
  assign restart_o = (st_q == HC_RESTART);
  assign active_o  = (st_q != HC_IDLE);

  assert_restart_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st_q == HC_IDLE));
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(RETRY_PERIODS));
endmodule

// File: rtl/fsv_fault_supervisor.sv
module fsv_fault_supervisor #(
  parameter int NUM_RAILS     = 2,
  parameter int RETRY_PERIODS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] uv_flag,
  input  logic [NUM_RAILS-1:0] ov_flag,
  input  logic                 tt_oc,
  input  logic                 temp_hot,
  input  logic                 temp_cool,
  input  logic                 slp5_n,
  input  logic                 por_ok,
  input  logic                 ss_tick,
  input  logic                 ramp_busy,
  input  logic                 in_s0,
  input  logic                 tt_win_hi,
  input  logic                 tt_win_lo,
  output logic                 all_off,
  output logic                 tt_off,
  output logic                 ss_restart,
  output logic                 pgood,
  output logic                 stat_ov,
  output logic                 stat_ot,
  output logic                 stat_uv
);
  localparam int NSCALAR = 8;
  localparam int NF      = 2 * NUM_RAILS + NSCALAR;

  logic [NF-1:0]        raw_vec, flt_vec;
  logic [NUM_RAILS-1:0] uv_f, ov_f;
  logic oc_f, hot_f, cool_f, s5_f, por_lost_f, s0_f, hi_f, lo_f;

  assign raw_vec = {ov_flag, uv_flag, tt_win_lo, tt_win_hi, in_s0, ~por_ok,
                    slp5_n, temp_cool, temp_hot, tt_oc};

  fsv_sync_filter #(.W(NF)) u_filter (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_vec),
    .dout (flt_vec)
  );

  assign oc_f       = flt_vec[0];
  assign hot_f      = flt_vec[1];
  assign cool_f     = flt_vec[2];
  assign s5_f       = flt_vec[3];
  assign por_lost_f = flt_vec[4];
  assign s0_f       = flt_vec[5];
  assign hi_f       = flt_vec[6];
  assign lo_f       = flt_vec[7];
  assign uv_f       = flt_vec[NSCALAR +: NUM_RAILS];
  assign ov_f       = flt_vec[NSCALAR + NUM_RAILS +: NUM_RAILS];

  // local registers
  logic s5_prev_q, s5_prev_d;
  logic oc_q, oc_d;
  logic pg_q, pg_d;

  always_comb begin
    s5_prev_d = s5_f;
    oc_d      = oc_f;
    if (!s0_f)     pg_d = 1'b0;
    else if (hi_f) pg_d = 1'b1;
    else if (lo_f) pg_d = 1'b0;
    else           pg_d = pg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s5_prev_q <= 1'b0;
      oc_q      <= 1'b0;
      pg_q      <= 1'b0;
    end else begin
      s5_prev_q <= s5_prev_d;
      oc_q      <= oc_d;
      pg_q      <= pg_d;
    end
  end

  logic clr_evt, ov_any, uv_any;
  assign clr_evt = por_lost_f | (s5_f & ~s5_prev_q);
  assign ov_any  = |ov_f;
  assign uv_any  = |uv_f;

  logic ov_q, ot_q;

  fsv_hard_latch u_ov_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ov_any),
    .clr_i   (clr_evt),
    .clr_ok_i(1'b1),
    .q_o     (ov_q)
  );

  fsv_hard_latch u_ot_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (hot_f),
    .clr_i   (clr_evt),
    .clr_ok_i(cool_f & ~hot_f),
    .q_o     (ot_q)
  );

  logic hard_hold, hic_off, hic_restart, hic_active;
  assign hard_hold = ov_any | hot_f | ov_q | ot_q;

  fsv_hiccup #(.RETRY_PERIODS(RETRY_PERIODS)) u_hiccup (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_hit   (uv_any & ~ramp_busy),
    .hold     (hard_hold),
    .ss_tick  (ss_tick),
    .off_o    (hic_off),
    .restart_o(hic_restart),
    .active_o (hic_active)
  );

  assign all_off    = ov_q | ot_q | hic_off;
  assign tt_off     = oc_q;
  assign ss_restart = hic_restart;
  assign pgood      = pg_q & ~all_off;
  assign stat_ov    = ov_q;
  assign stat_ot    = ot_q;
  assign stat_uv    = hic_active;

  assert_pg_s0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_f |=> !pgood);
  assert_ov_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ov_any |=> all_off);
endmodule

// File: tb/fsv_fault_supervisor_tb.sv
module fsv_fault_supervisor_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] uv_flag, ov_flag;
  logic tt_oc, temp_hot, temp_cool, slp5_n, por_ok, ss_tick, ramp_busy;
  logic in_s0, tt_win_hi, tt_win_lo;
  logic all_off, tt_off, ss_restart, pgood, stat_ov, stat_ot, stat_uv;

  fsv_fault_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .tt_oc(tt_oc), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .slp5_n(slp5_n), .por_ok(por_ok), .ss_tick(ss_tick),
    .ramp_busy(ramp_busy), .in_s0(in_s0), .tt_win_hi(tt_win_hi),
    .tt_win_lo(tt_win_lo), .all_off(all_off), .tt_off(tt_off),
    .ss_restart(ss_restart), .pgood(pgood), .stat_ov(stat_ov),
    .stat_ot(stat_ot), .stat_uv(stat_uv)
  );

  // expected vector order: {all_off, tt_off, ss_restart, pgood, stat_ov, stat_ot, stat_uv}
  typedef struct {
    int         due;
    logic [6:0] v;
    string      tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    logic [6:0] got;
    got = {all_off, tt_off, ss_restart, pgood, stat_ov, stat_ot, stat_uv};
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (got !== it.v) begin
        bad++;
        $display("FAIL %s cycle=%0d got=%b exp=%b", it.tag, cyc, got, it.v);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int d, input logic [6:0] v, input string tag);
    item_t it;
    it.due = cyc + d;
    it.v   = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pulse_tick();
    ss_tick = 1'b1;
    step(1);
    ss_tick = 1'b0;
    step(2);
  endtask

  task automatic s5_toggle();
    slp5_n = 1'b0;
    step(4);
    slp5_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    uv_flag = '0; ov_flag = '0; tt_oc = 0; temp_hot = 0; temp_cool = 0;
    slp5_n = 1; por_ok = 1; ss_tick = 0; ramp_busy = 0;
    in_s0 = 0; tt_win_hi = 0; tt_win_lo = 0;
    step(3);
    rst_n = 1'b1;
    chk(0, 7'b0000000, "R11");
    step(6);
    chk(0, 7'b0000000, "R11");
    step(1);

    // power-good window (R8)
    in_s0 = 1; tt_win_hi = 1; chk(4, 7'b0001000, "R8"); step(6);
    tt_win_hi = 0;            chk(4, 7'b0001000, "R8"); step(6);
    tt_win_lo = 1;            chk(4, 7'b0000000, "R8"); step(6);
    tt_win_lo = 0; tt_win_hi = 1; chk(4, 7'b0001000, "R8"); step(6);
    in_s0 = 0;                chk(4, 7'b0000000, "R8"); step(6);
    in_s0 = 1;                chk(4, 7'b0001000, "R8"); step(6);

    // single-cycle glitch ignored (R10)
    uv_flag[0] = 1; step(1); uv_flag[0] = 0;
    chk(3, 7'b0001000, "R10"); chk(4, 7'b0001000, "R10"); chk(5, 7'b0001000, "R10");
    step(8);

    // hiccup (R1, R2, R10)
    uv_flag[1] = 1;
    chk(3, 7'b0001000, "R10");
    chk(4, 7'b1000001, "R1/R10");
    step(6);
    pulse_tick();
    pulse_tick();
    chk(0, 7'b1000001, "R1");
    ss_tick = 1;
    chk(1, 7'b0011001, "R1");
    step(1);
    ss_tick = 0;
    chk(1, 7'b0001000, "R1");
    chk(2, 7'b1000001, "R2");
    step(4);
    uv_flag[1] = 0;
    step(6);
    chk(0, 7'b1000001, "R2");
    pulse_tick();
    pulse_tick();
    ss_tick = 1;
    chk(1, 7'b0011001, "R2");
    step(1);
    ss_tick = 0;
    chk(1, 7'b0001000, "R2");
    chk(2, 7'b0001000, "R2");
    step(6);
    chk(0, 7'b0001000, "R2");

    // masking during ramp (R7)
    ramp_busy = 1; uv_flag[0] = 1;
    chk(4, 7'b0001000, "R7"); chk(7, 7'b0001000, "R7");
    step(8);
    uv_flag[0] = 0;
    step(5);
    ramp_busy = 0;
    chk(2, 7'b0001000, "R7");
    step(4);

    // termination over-current (R6)
    tt_oc = 1; chk(4, 7'b0101000, "R6"); step(6);
    tt_oc = 0; chk(4, 7'b0001000, "R6"); step(6);

    // over-voltage latch (R3, R4)
    ov_flag[1] = 1; chk(4, 7'b1000100, "R3"); step(6);
    ov_flag[1] = 0; chk(6, 7'b1000100, "R4"); step(8);
    slp5_n = 0;     chk(5, 7'b1000100, "R4"); step(6);
    slp5_n = 1;     chk(4, 7'b0001000, "R4"); step(6);
    ov_flag[0] = 1; step(6);
    ov_flag[0] = 0; step(6);
    chk(0, 7'b1000100, "R4");
    por_ok = 0;     chk(4, 7'b0001000, "R4"); step(3);
    por_ok = 1;     step(6);
    chk(0, 7'b0001000, "R4");

    // priority over retry loop (R9)
    ov_flag[0] = 1; uv_flag[0] = 1;
    chk(4, 7'b1000100, "R9"); step(6);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk(0, 7'b1000100, "R9"); chk(1, 7'b1000100, "R9");
    step(2);
    ov_flag[0] = 0; uv_flag[0] = 0; step(6);
    s5_toggle();
    chk(4, 7'b0001000, "R9"); step(6);

    // thermal latch (R5)
    temp_hot = 1; chk(4, 7'b1000010, "R5"); step(6);
    temp_hot = 0; step(4);
    s5_toggle();
    chk(4, 7'b1000010, "R5"); step(6);
    temp_cool = 1; step(4);
    s5_toggle();
    chk(4, 7'b0001000, "R5"); step(6);

    step(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired cycle=%0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule